// File: doc/BRIEF.md
# Low-Voltage Reset Deglitch Controller

This block turns a comparator flag into a clean chip-reset request. The flag reports that the analog supply is below the low-voltage trip point. The flag arrives asynchronously and first passes through a two-stage synchronizer. A filter then converts it into a reset request. The filter asserts the request only after the supply has been low for a full deglitch window, and it withdraws the request only after the supply has been good for the same window. Detection is gated by an enable bit. After the enable is set, a fixed settling time, computed from the clock frequency parameter, must pass before any request can be raised.

Software reaches the block through a small register port with registered reads. The control word holds the enable and a three-bit window select. The window is 0 cycles for code 0; codes 1 to 7 give 4, 8, 16 and so on up to 256 cycles. The status word holds two sticky cause flags, each cleared by writing 1:
- one flag is set by power-on reset;
- the other is set each time the low-voltage request asserts.

The synchronous power-on reset input returns every register to its default. The defaults are detection enabled with no deglitch, so after settling the request follows the synchronized comparator directly.

Top module: `lvr_guard`

## Requirements
- R1: After power-on reset, `lvr_rst_o` is 0. Control (address 0) reads 0x00000080, meaning enable bit 7 = 1 and window select bits 14:12 = 0. Status (address 1) reads 0x00000001, meaning power-on flag bit 0 = 1 and low-voltage flag bit 1 = 0.
- R2: While the enable is set, no request is raised until SETTLE_US microseconds of clock cycles (CLK_HZ/1e6 × SETTLE_US) have elapsed since the enable took effect or since reset. With a low supply and select 0, the request rises on the cycle after settling completes.
- R3: With select 0 and settling done, `lvr_rst_o` follows `vdd_low_i` in both directions with a latency of three clock edges. Two of those edges are the synchronizer and one is the output register.
- R4: With select code c (1..7), the window is W = 4·2^(c-1) cycles. A low pulse lasting W-1 cycles raises no request. A low level held from time t0 raises the request W+2 edges after t0.
- R5: While the request is active, a good-supply pulse of W-1 cycles does not release it. A good supply held from time t0 releases it W+2 edges after t0.
- R6: If the synchronized input returns to its current state before the window completes, the window count restarts from zero. Two low pulses of W-1 cycles separated by a single good cycle raise no request.
- R7: Writing the control word with bit 7 = 0 drops `lvr_rst_o` by the second edge after the write edge and restarts the settling timer. When the enable is set again with the supply still low, the request returns only after the full settling time plus the window.
- R8: Writing status with bit 0 = 1 clears the power-on flag. Writing 0 to that bit has no effect.
- R9: The low-voltage flag (status bit 1) is set on each rising edge of the request. It stays set when the request falls and is cleared by writing 1 to bit 1. If a set and a clear fall on the same edge, the set wins.
- R10: Read data appears one edge after the read address is presented. Control bits other than 7 and 14:12 read as 0, and addresses other than 0 and 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed-frequency clock of CLK_HZ |
| rst | input | 1 | Synchronous active-high power-on reset |
| vdd_low_i | input | 1 | Asynchronous comparator flag, 1 = supply below trip point |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 control, 1 status) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| lvr_rst_o | output | 1 | Filtered low-voltage reset request |

## Verification
The two functions that can fall on the same edge are the setting of the low-voltage cause flag and a software write-1 clear of that flag. The bench sets this up by raising the request with a held low supply and polling the output between edges. On the first half-cycle in which the output is seen high, it issues the status clear, which lands on exactly the edge where the flag is set. The bench then reads the status back and requires bit 1 to be 1, which shows that the set took priority. A later plain clear must still succeed.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  localparam int unsigned CTRL_EN_BIT  = 7;
  localparam int unsigned CTRL_SEL_LSB = 12;
  localparam int unsigned SEL_W        = 3;
  localparam int unsigned STS_POR_BIT  = 0;
  localparam int unsigned STS_LVR_BIT  = 1;
  localparam int unsigned ADDR_CTRL    = 0;
  localparam int unsigned ADDR_STS     = 1;

  // Window length in cycles for a select code: 0 = none, then base doubling.
  function automatic int unsigned dg_window(input logic [SEL_W-1:0] code,
                                            input int unsigned base);
    if (code == '0) return 0;
    return base << (int'(code) - 1);
  endfunction
endpackage

// File: rtl/lvr_sync.sv
module lvr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lvr_settle.sv
module lvr_settle #(
  parameter int unsigned LIMIT = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = en_i && (cnt_q == LIM);

  p_settle_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM);
endmodule

// File: rtl/lvr_filter.sv
module lvr_filter
  import lvr_pkg::*;
#(
  parameter int unsigned DG_BASE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             sync_i,
  output logic             active_o
);
  localparam int unsigned WIN_MAX = DG_BASE << ((1 << SEL_W) - 2);
  localparam int unsigned FW      = $clog2(WIN_MAX + 1);

  logic [FW-1:0] cnt_q;
  logic [FW-1:0] win;
  logic [FW-1:0] last;
  logic          active_q;

  assign win  = FW'(dg_window(sel_i, DG_BASE));
  assign last = win - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!ready_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (sel_i == '0) begin
      active_q <= sync_i;
      cnt_q    <= '0;
    end else if (sync_i != active_q) begin
      if (cnt_q >= last) begin
        active_q <= ~active_q;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign active_o = active_q;

  // A matching input never moves the request (R4, R5, R6).
  p_no_flip_matched_r4: assert property (@(posedge clk) disable iff (rst)
    (ready_i && (sync_i == active_q)) |=> $stable(active_q));
endmodule

// File: rtl/lvr_regs.sv
module lvr_regs
  import lvr_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lvr_rst_i,
  output logic              en_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             por_flag_q;
  logic             lvr_flag_q;
  logic             req_prev_q;
  logic             wr_ctrl, wr_sts;
  logic             clr_por, clr_lvr, set_lvr;
  logic [DATA_W-1:0] ctrl_word, sts_word, rd_next;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign wr_sts  = wr_en && (wr_addr == ADDR_W'(ADDR_STS));
  assign clr_por = wr_sts && wr_data[STS_POR_BIT];
  assign clr_lvr = wr_sts && wr_data[STS_LVR_BIT];
  assign set_lvr = lvr_rst_i && !req_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b1;
      sel_q <= '0;
    end else if (wr_ctrl) begin
      en_q  <= wr_data[CTRL_EN_BIT];
      sel_q <= wr_data[CTRL_SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      por_flag_q <= 1'b1;
      lvr_flag_q <= 1'b0;
      req_prev_q <= 1'b0;
    end else begin
      req_prev_q <= lvr_rst_i;
      if (clr_por) por_flag_q <= 1'b0;
      if (set_lvr)      lvr_flag_q <= 1'b1;
      else if (clr_lvr) lvr_flag_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT] = en_q;
    ctrl_word[CTRL_SEL_LSB +: SEL_W] = sel_q;
    sts_word = '0;
    sts_word[STS_POR_BIT] = por_flag_q;
    sts_word[STS_LVR_BIT] = lvr_flag_q;
    if (rd_addr == ADDR_W'(ADDR_CTRL))     rd_next = ctrl_word;
    else if (rd_addr == ADDR_W'(ADDR_STS)) rd_next = sts_word;
    else                                   rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assign en_o  = en_q;
  assign sel_o = sel_q;

  p_por_flag_no_set_r8: assert property (@(posedge clk) disable iff (rst)
    !por_flag_q |=> !por_flag_q);

  p_lvr_flag_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(lvr_rst_i) |=> lvr_flag_q);

  p_lvr_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (lvr_flag_q && !clr_lvr) |=> lvr_flag_q);
endmodule

// File: rtl/lvr_guard.sv
module lvr_guard
  import lvr_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned SETTLE_US = 200,
  parameter int unsigned DG_BASE   = 4,
  parameter int unsigned SYNC_STG  = 2,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vdd_low_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              lvr_rst_o
);
  localparam int unsigned SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;

  logic             ctrl_en;
  logic [SEL_W-1:0] ctrl_sel;
  logic             settled;
  logic             low_sync;
  logic             req;

  lvr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .lvr_rst_i(req), .en_o(ctrl_en), .sel_o(ctrl_sel)
  );

  lvr_sync #(.STAGES(SYNC_STG)) sync_i (
    .clk(clk), .rst(rst), .async_i(vdd_low_i), .sync_o(low_sync)
  );

  lvr_settle #(.LIMIT(SETTLE_CYC)) settle_i (
    .clk(clk), .rst(rst), .en_i(ctrl_en), .ready_o(settled)
  );

  lvr_filter #(.DG_BASE(DG_BASE)) filter_i (
    .clk(clk), .rst(rst), .ready_i(settled), .sel_i(ctrl_sel),
    .sync_i(low_sync), .active_o(req)
  );

  assign lvr_rst_o = req;

  p_release_on_disable_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !lvr_rst_o);

  p_quiet_until_settled_r2: assert property (@(posedge clk) disable iff (rst)
    !settled |=> !lvr_rst_o);
endmodule

// File: tb/lvr_guard_tb_top.sv
`timescale 1ns/1ps
module lvr_guard_tb_top;
  localparam int unsigned CLK_HZ = 100_000_000;
  localparam int unsigned SET_US = 200;
  localparam int unsigned LIMIT  = (CLK_HZ / 1_000_000) * SET_US;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vdd_low_i = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        lvr_rst_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int ecnt   = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ecnt <= 0;
    else     ecnt <= ecnt + 1;
  end

  lvr_guard #(.CLK_HZ(CLK_HZ), .SETTLE_US(SET_US)) dut_i (
    .clk(clk), .rst(rst), .vdd_low_i(vdd_low_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .lvr_rst_o(lvr_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // Drive the comparator to v and count edges until the output equals v.
  task automatic latency(input logic v, input int lim, output int k);
    vdd_low_i = v;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (lvr_rst_o !== v && k < lim);
  endtask

  function automatic int win_of(input int c);
    return (c == 0) ? 0 : (4 << (c - 1));
  endfunction

  task automatic t_reset_and_settle();
    logic [31:0] d;
    step(3);
    rst = 1'b0;
    vdd_low_i = 1'b1;
    check("R1 request after reset", {31'b0, lvr_rst_o}, 32'h0);
    reg_rd(2'd0, d); check("R1 control default", d, 32'h0000_0080);
    reg_rd(2'd1, d); check("R1 status default", d, 32'h0000_0001);
    reg_rd(2'd2, d); check("R10 unmapped address", d, 32'h0);
    while (ecnt < LIMIT) @(negedge clk);
    check("R2 quiet during settling", {31'b0, lvr_rst_o}, 32'h0);
    @(negedge clk);
    check("R2 request right after settling", {31'b0, lvr_rst_o}, 32'h1);
  endtask

  task automatic t_direct();
    int k;
    logic [31:0] d;
    latency(1'b0, 20, k); check("R3 release latency sel 0", k, 3);
    latency(1'b1, 20, k); check("R3 assert latency sel 0", k, 3);
    latency(1'b0, 20, k); check("R3 second release latency", k, 3);
    reg_rd(2'd1, d); check("R9 flag kept after request falls", d, 32'h3);
  endtask

  task automatic t_flags();
    logic [31:0] d;
    reg_wr(2'd1, 32'h0);
    reg_rd(2'd1, d); check("R8 writing zeros changes nothing", d, 32'h3);
    reg_wr(2'd1, 32'h2);
    reg_rd(2'd1, d); check("R9 clear low-voltage flag", d, 32'h1);
    reg_wr(2'd1, 32'h1);
    reg_rd(2'd1, d); check("R8 clear power-on flag", d, 32'h0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] d;
    reg_wr(2'd0, 32'hFFFF_FFFF);
    reg_rd(2'd0, d); check("R10 control unused bits read zero", d, 32'h0000_7080);
  endtask

  task automatic t_windows();
    int k, w;
    for (int c = 1; c <= 7; c++) begin
      w = win_of(c);
      reg_wr(2'd0, (c << 12) | 32'h80);
      step(2);
      vdd_low_i = 1'b1; step(w - 1); vdd_low_i = 1'b0; step(w + 4);
      check($sformatf("R4 short low pulse ignored code %0d", c), {31'b0, lvr_rst_o}, 32'h0);
      latency(1'b1, w + 20, k);
      check($sformatf("R4 assert latency code %0d", c), k, w + 2);
      vdd_low_i = 1'b0; step(w - 1); vdd_low_i = 1'b1; step(w + 4);
      check($sformatf("R5 short good pulse ignored code %0d", c), {31'b0, lvr_rst_o}, 32'h1);
      latency(1'b0, w + 20, k);
      check($sformatf("R5 release latency code %0d", c), k, w + 2);
    end
  endtask

  task automatic t_restart();
    bit seen = 1'b0;
    reg_wr(2'd0, 32'h1080);
    step(2);
    vdd_low_i = 1'b1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); seen |= lvr_rst_o; end
    vdd_low_i = 1'b0;
    @(negedge clk); seen |= lvr_rst_o;
    vdd_low_i = 1'b1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); seen |= lvr_rst_o; end
    vdd_low_i = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); seen |= lvr_rst_o; end
    check("R6 interrupted window restarts", {31'b0, seen}, 32'h0);
  endtask

  task automatic t_disable();
    int k;
    logic [31:0] d;
    latency(1'b1, 20, k); check("R4 assert before disable", k, 6);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h1000;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R7 disable drops request", {31'b0, lvr_rst_o}, 32'h0);
    step(10);
    check("R7 stays low while disabled", {31'b0, lvr_rst_o}, 32'h0);
    wr_en = 1'b1; wr_data = 32'h1080;
    @(negedge clk);
    wr_en = 1'b0;
    step(LIMIT + 4 - 1);
    check("R7 re-enable waits settle plus window", {31'b0, lvr_rst_o}, 32'h0);
    @(negedge clk);
    check("R7 request returns after settle", {31'b0, lvr_rst_o}, 32'h1);
    reg_rd(2'd1, d); check("R9 flag set by new request", d, 32'h2);
  endtask

  task automatic t_collide();
    int k;
    logic [31:0] d;
    reg_wr(2'd1, 32'h2);
    latency(1'b0, 20, k); check("R5 release before collision", k, 6);
    reg_rd(2'd1, d); check("R9 flag clear before collision", d, 32'h0);
    vdd_low_i = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (lvr_rst_o !== 1'b1 && k < 20);
    reg_wr(2'd1, 32'h2);
    reg_rd(2'd1, d); check("R9 set wins over same-edge clear", d, 32'h2);
    reg_wr(2'd1, 32'h2);
    reg_rd(2'd1, d); check("R9 later clear succeeds", d, 32'h0);
  endtask

  initial begin
    t_reset_and_settle();
    t_direct();
    t_flags();
    t_ctrl_rw();
    t_windows();
    t_restart();
    t_disable();
    t_collide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule